// File: doc/BRIEF.md
# Flash Control Register Block

This block holds the small set of byte-wide registers that steer an embedded flash array through its program and erase sequences. A host reaches the registers over a plain synchronous register bus: an offset, a write strobe and write data, with read data returned combinationally for whatever offset is presented. The stored bits drive level outputs to the array: erase selection, the program latch enable, the high-voltage enable and a stop-in-wait flag. A status input from the voltage sensor appears as a read-only bit.

Two guards protect the array. A lock bit freezes the configuration register. The configuration register's boot-guard bit screens array write strobes: a strobe aimed at the boot window is withheld from the array and reported by a one-cycle pulse. The high-voltage enable can only be raised once the latch enable is already set, so voltage is never applied without latched data.

Top module: `flashctl_regblk`

## Requirements
- R1: After reset, offsets 0x4, 0x5, 0x6 and 0x7 read 0x00, 0x01, 0x00 and 0x00 (with `vpp_ok` low). `boot_guard` is 1 and `erase_mode`, `latch_en`, `hv_en` and `wait_stop` are 0.
- R2: The lock, configuration, test and control registers sit at offsets 0x4, 0x5, 0x6 and 0x7 in that order. Every other offset reads 0x00.
- R3: The lock register stores write-data bit 0 in its bit 0. Bits 7 to 1 read 0.
- R4: While the lock bit is 1, writes to the configuration register leave it unchanged. While the lock bit is 0, write-data bit 0 is stored in configuration bit 0 (the boot guard, driven on `boot_guard`). Configuration bits 7 to 1 read 0.
- R5: The test register reads 0x00 whatever was written to it.
- R6: In the control register, bit 4 is stop-in-wait, bit 2 is erase select, bit 1 is latch enable and bit 0 is high-voltage enable. Each is driven on its own output port. Bits 7 to 5 read 0.
- R7: Control bit 3 reads the present value of `vpp_ok`. Writes to bit 3 are ignored.
- R8: A control write stores 1 in bit 0 only if the latch enable was already 1 before the write and the same write keeps bit 1 set. Otherwise bit 0 becomes 0.
- R9: While `boot_guard` is 1, an `arr_we` at an `arr_addr` in 0x7800..0x7FFF inclusive is withheld (`arr_we_out` stays 0 in that cycle). `arr_wr_ignored` is 1 for exactly the following cycle. Strobes outside that window, or any strobe while `boot_guard` is 0, pass to `arr_we_out` in the same cycle and raise no pulse.
- R10: A register write takes effect at the single clock edge on which `reg_we` is sampled high. The new value can be read right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register offset within the page |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| vpp_ok | input | 1 | Programming-voltage-near-nominal status |
| arr_we | input | 1 | Array write strobe from the host |
| arr_addr | input | 16 | Array byte address of the write strobe |
| arr_we_out | output | 1 | Array write strobe after boot screening |
| arr_wr_ignored | output | 1 | One-cycle pulse after a withheld boot write |
| erase_mode | output | 1 | Erase select level to the array |
| latch_en | output | 1 | Program latch enable level |
| hv_en | output | 1 | High-voltage enable level |
| wait_stop | output | 1 | Stop flash clock in wait |
| boot_guard | output | 1 | Boot window protection level |

## Verification
A wrong stored bit shows as soon as its offset is read back after the writing edge. Each control bit also has its own output pin, so a corrupt control field is visible on that pin one cycle after the write. A lock that fails to hold, or a boot guard that fails to clear, shows on `boot_guard` in the very next cycle. It then shows on `arr_we_out` in the same cycle as the next array strobe into the boot window. A wrong window bound or a missing pulse appears one cycle later on `arr_wr_ignored`. A high-voltage enable raised without a prior latch appears on `hv_en` right after the offending write.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    localparam int unsigned REG_DW = 8;

    localparam int unsigned BIT_HV    = 0;
    localparam int unsigned BIT_LATCH = 1;
    localparam int unsigned BIT_ERASE = 2;
    localparam int unsigned BIT_VSTAT = 3;
    localparam int unsigned BIT_WAIT  = 4;

    typedef enum logic [1:0] {
        SEL_LOCK = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_TEST = 2'd2,
        SEL_CTL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wait_stop;
        logic erase_mode;
        logic latch_en;
        logic hv_en;
    } ctl_t;

    function automatic logic [REG_DW-1:0] pack_ctl(input ctl_t c, input logic vstat);
        logic [REG_DW-1:0] v;
        v            = '0;
        v[BIT_WAIT]  = c.wait_stop;
        v[BIT_VSTAT] = vstat;
        v[BIT_ERASE] = c.erase_mode;
        v[BIT_LATCH] = c.latch_en;
        v[BIT_HV]    = c.hv_en;
        return v;
    endfunction

endpackage

// File: rtl/flashctl_decode.sv
module flashctl_decode
    import flashctl_pkg::*;
#(
    parameter int unsigned RAW      = 8,
    parameter int unsigned REG_BASE = 4
) (
    input  logic [RAW-1:0] reg_addr,
    output logic           hit,
    output reg_sel_e       sel
);
    localparam logic [RAW-1:0] OFF_BASE = RAW'(REG_BASE);
    localparam logic [RAW-1:0] NUM_REGS = RAW'(4);

    logic [RAW-1:0] rel;

    always_comb begin
        rel = reg_addr - OFF_BASE;
        hit = (reg_addr >= OFF_BASE) && (rel < NUM_REGS);
        sel = reg_sel_e'(rel[1:0]);
    end
endmodule

// File: rtl/flashctl_regfile.sv
module flashctl_regfile
    import flashctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [REG_DW-1:0] wdata,
    output logic              lock_o,
    output logic              guard_o,
    output ctl_t              ctl_o
);
    logic lock_q;
    logic guard_q;
    ctl_t ctl_q;
    ctl_t ctl_nxt;
    logic [3:0] unused_wdata;

    assign unused_wdata = {wdata[REG_DW-1:5], wdata[BIT_VSTAT]};

    always_comb begin
        ctl_nxt.wait_stop  = wdata[BIT_WAIT];
        ctl_nxt.erase_mode = wdata[BIT_ERASE];
        ctl_nxt.latch_en   = wdata[BIT_LATCH];
        // voltage only with latch already set and kept set
        ctl_nxt.hv_en      = wdata[BIT_HV] & ctl_q.latch_en & wdata[BIT_LATCH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            guard_q <= 1'b1;
            ctl_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_LOCK: lock_q <= wdata[0];
                SEL_CFG:  if (!lock_q) guard_q <= wdata[0];
                SEL_CTL:  ctl_q <= ctl_nxt;
                default:  ;
            endcase
        end
    end

    assign lock_o  = lock_q;
    assign guard_o = guard_q;
    assign ctl_o   = ctl_q;

    a_r4_cfg_frozen_when_locked: assert property (@(posedge clk) disable iff (rst)
        (lock_q && wr_en && sel == SEL_CFG) |=> $stable(guard_q));

    a_r8_hv_rise_needs_latch: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.hv_en) |-> $past(ctl_q.latch_en));

    a_r8_hv_implies_latch: assert property (@(posedge clk) disable iff (rst)
        ctl_q.hv_en |-> ctl_q.latch_en);
endmodule

// File: rtl/flashctl_boot_guard.sv
module flashctl_boot_guard #(
    parameter int unsigned          ARR_AW  = 16,
    parameter logic [ARR_AW-1:0]    BOOT_LO = 'h7800,
    parameter logic [ARR_AW-1:0]    BOOT_HI = 'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_we,
    input  logic [ARR_AW-1:0] arr_addr,
    input  logic              guard,
    output logic              arr_we_out,
    output logic              ignored_pulse
);
    logic in_win;
    logic withheld;
    logic pulse_q;

    always_comb begin
        in_win     = (arr_addr >= BOOT_LO) && (arr_addr <= BOOT_HI);
        withheld   = arr_we & guard & in_win;
        arr_we_out = arr_we & ~withheld;
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= withheld;
    end

    assign ignored_pulse = pulse_q;

    a_r9_pulse_follows_attempt: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(arr_we && guard && in_win));
endmodule

// File: rtl/flashctl_regblk.sv
module flashctl_regblk
    import flashctl_pkg::*;
#(
    parameter int unsigned       RAW      = 8,
    parameter int unsigned       REG_BASE = 4,
    parameter int unsigned       ARR_AW   = 16,
    parameter logic [ARR_AW-1:0] BOOT_LO  = 'h7800,
    parameter logic [ARR_AW-1:0] BOOT_HI  = 'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAW-1:0]    reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              vpp_ok,
    input  logic              arr_we,
    input  logic [ARR_AW-1:0] arr_addr,
    output logic              arr_we_out,
    output logic              arr_wr_ignored,
    output logic              erase_mode,
    output logic              latch_en,
    output logic              hv_en,
    output logic              wait_stop,
    output logic              boot_guard
);
    localparam logic [RAW-1:0] OFF_LOCK = RAW'(REG_BASE);
    localparam logic [RAW-1:0] OFF_TEST = RAW'(REG_BASE + 2);
    localparam logic [RAW-1:0] OFF_CTL  = RAW'(REG_BASE + 3);

    logic     hit;
    reg_sel_e sel;
    logic     lock_s;
    logic     guard_s;
    ctl_t     ctl_s;

    flashctl_decode #(.RAW(RAW), .REG_BASE(REG_BASE)) u_dec (
        .reg_addr (reg_addr),
        .hit      (hit),
        .sel      (sel)
    );

    flashctl_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we & hit),
        .sel     (sel),
        .wdata   (reg_wdata),
        .lock_o  (lock_s),
        .guard_o (guard_s),
        .ctl_o   (ctl_s)
    );

    flashctl_boot_guard #(.ARR_AW(ARR_AW), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)) u_boot (
        .clk           (clk),
        .rst           (rst),
        .arr_we        (arr_we),
        .arr_addr      (arr_addr),
        .guard         (guard_s),
        .arr_we_out    (arr_we_out),
        .ignored_pulse (arr_wr_ignored)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (sel)
                SEL_LOCK: reg_rdata[0] = lock_s;
                SEL_CFG:  reg_rdata[0] = guard_s;
                SEL_CTL:  reg_rdata    = pack_ctl(ctl_s, vpp_ok);
                default:  reg_rdata    = '0;
            endcase
        end
    end

    assign erase_mode = ctl_s.erase_mode;
    assign latch_en   = ctl_s.latch_en;
    assign hv_en      = ctl_s.hv_en;
    assign wait_stop  = ctl_s.wait_stop;
    assign boot_guard = guard_s;

    a_r9_no_boot_strobe_passes: assert property (@(posedge clk) disable iff (rst)
        arr_we_out |-> !(boot_guard && arr_addr >= BOOT_LO && arr_addr <= BOOT_HI));

    a_r5_test_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_TEST) |-> (reg_rdata == '0));

    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < OFF_LOCK || reg_addr > OFF_CTL) |-> (reg_rdata == '0));

    a_r7_vstat_mirrors_input: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CTL) |-> (reg_rdata[3] == vpp_ok));

    a_r6_ctl_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CTL) |-> (reg_rdata[7:5] == 3'b000));
endmodule

// File: tb/tb_flashctl_regblk.sv
module tb_flashctl_regblk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        vpp_ok = 1'b0;
    logic        arr_we = 1'b0;
    logic [15:0] arr_addr = '0;
    logic        arr_we_out, arr_wr_ignored;
    logic        erase_mode, latch_en, hv_en, wait_stop, boot_guard;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flashctl_regblk dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vpp_ok(vpp_ok),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_we_out(arr_we_out),
        .arr_wr_ignored(arr_wr_ignored), .erase_mode(erase_mode),
        .latch_en(latch_en), .hv_en(hv_en), .wait_stop(wait_stop),
        .boot_guard(boot_guard)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h04, d); chk("R1 lock", d, 8'h00);
        rd(8'h05, d); chk("R1 cfg", d, 8'h01);
        rd(8'h06, d); chk("R1 test", d, 8'h00);
        rd(8'h07, d); chk("R1 ctl", d, 8'h00);
        chk("R1 outputs", {11'd0, boot_guard, erase_mode, latch_en, hv_en, wait_stop}, 16'h0010);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(8'h07, 8'h16);
        rd(8'h03, d); chk("R2 offset 0x03", d, 8'h00);
        rd(8'h08, d); chk("R2 offset 0x08", d, 8'h00);
        rd(8'h00, d); chk("R2 offset 0x00", d, 8'h00);
        rd(8'hFF, d); chk("R2 offset 0xFF", d, 8'h00);
        wr(8'h03, 8'hFF);
        rd(8'h04, d); chk("R2 stray write leaves lock", d, 8'h00);
        wr(8'h07, 8'h00);
    endtask

    task automatic t_lock_cfg();
        logic [7:0] d;
        wr(8'h04, 8'hFF);
        rd(8'h04, d); chk("R3 lock readback", d, 8'h01);
        wr(8'h05, 8'h00);
        rd(8'h05, d); chk("R4 cfg frozen", d, 8'h01);
        chk("R4 guard port frozen", {15'd0, boot_guard}, 16'h1);
        wr(8'h04, 8'h00);
        rd(8'h04, d); chk("R3 lock clear", d, 8'h00);
        wr(8'h05, 8'h00);
        rd(8'h05, d); chk("R4 cfg cleared", d, 8'h00);
        chk("R4 guard port low", {15'd0, boot_guard}, 16'h0);
        wr(8'h05, 8'hFF);
        rd(8'h05, d); chk("R4 cfg set", d, 8'h01);
    endtask

    task automatic t_test_reg();
        logic [7:0] d;
        wr(8'h06, 8'hFF);
        rd(8'h06, d); chk("R5 test reads zero", d, 8'h00);
    endtask

    task automatic t_ctl();
        logic [7:0] d;
        wr(8'h07, 8'hF6);
        rd(8'h07, d); chk("R6 R10 ctl readback", d, 8'h16);
        chk("R6 ctl ports", {12'd0, wait_stop, erase_mode, latch_en, hv_en}, 16'hE);
        wr(8'h07, 8'hFF);
        rd(8'h07, d); chk("R8 hv with latch held", d, 8'h17);
        chk("R8 hv port", {15'd0, hv_en}, 16'h1);
        wr(8'h07, 8'h01);
        rd(8'h07, d); chk("R8 hv dropped when latch cleared", d, 8'h00);
        wr(8'h07, 8'h03);
        rd(8'h07, d); chk("R8 hv blocked without prior latch", d, 8'h02);
        chk("R8 hv port low", {15'd0, hv_en}, 16'h0);
        wr(8'h07, 8'h00);
    endtask

    task automatic t_vstat();
        logic [7:0] d;
        vpp_ok = 1'b1;
        rd(8'h07, d); chk("R7 vstat high", d, 8'h08);
        vpp_ok = 1'b0;
        wr(8'h07, 8'h08);
        rd(8'h07, d); chk("R7 vstat write ignored", d, 8'h00);
    endtask

    task automatic arr_try(input string req, input logic [15:0] a, input logic pass);
        arr_addr = a; arr_we = 1'b1; #1;
        chk({req, " strobe"}, {15'd0, arr_we_out}, {15'd0, pass});
        @(posedge clk); #1;
        arr_we = 1'b0;
        chk({req, " pulse"}, {15'd0, arr_wr_ignored}, {15'd0, ~pass});
        @(posedge clk); #1;
        chk({req, " pulse ends"}, {15'd0, arr_wr_ignored}, 16'h0);
    endtask

    task automatic t_boot();
        arr_try("R9 low edge", 16'h7800, 1'b0);
        arr_try("R9 high edge", 16'h7FFF, 1'b0);
        arr_try("R9 below window", 16'h77FF, 1'b1);
        arr_try("R9 above window", 16'h8000, 1'b1);
        wr(8'h05, 8'h00);
        arr_try("R9 guard off", 16'h7800, 1'b1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_map();
        t_lock_cfg();
        t_test_reg();
        t_ctl();
        t_vstat();
        t_boot();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule